// File: doc/BRIEF.md
# Stereo Audio Concealment Interpolator

This block hides audio samples that upstream error correction could not repair. Samples arrive as 16-bit two's-complement words on a single input with a valid strobe. Each sample carries a channel tag (left or right) and an "uncorrectable" flag. Every channel keeps its own state. The block holds each sample back until the next sample of the same channel arrives, because the decision for a flagged sample depends on whether its successor is usable:

- A flagged sample whose successor is good becomes the midpoint between the last good value and that successor.
- A flagged sample whose successor is also flagged becomes the last good value.

So a lone error is interpolated. A burst is held flat and then eased into the next good sample with one interpolated step.

A raw-data mode turns concealment off, so samples leave exactly as they came in. A 2-bit sticky status reports whether any interpolation and/or hold happened since the last frame-start strobe. A system integrator places the block between the error corrector and the audio path. The stream must interleave channels so that each channel keeps advancing.

Top module: `conceal_interp`

## Requirements
- R1: Each accepted sample is emitted exactly once. It appears on the outputs one clock after the edge that accepts the next sample of the same channel, and `out_chan` carries that channel. The first sample of a channel after reset produces no output by itself.
- R2: Channels are independent. Flags, values and held state of one channel never affect what another channel emits.
- R3: A sample whose flag is 0 is emitted with its value unchanged.
- R4: A flagged sample whose successor in the same channel has flag 0 is emitted as (last good value + successor), formed as a sign-extended 17-bit sum and shifted right arithmetically by one bit (rounds toward minus infinity).
- R5: A flagged sample whose successor in the same channel is also flagged is emitted as the last good value of that channel.
- R6: After a run of two or more flagged samples, the last flagged sample of the run is emitted with the R4 midpoint of the held value and the next good sample.
- R7: Until a channel has emitted an unflagged sample since reset, its last good value is 0.
- R8: While `raw_mode` is 1 on the accepting edge, the emitted sample equals the stored input value even if it is flagged, and no status bit is set. The last good value still updates from unflagged samples.
- R9: `conceal_status` bit 0 is set by any interpolation (R4/R6) and bit 1 by any hold (R5). Both bits stay set until cleared. Code 00 means none, 01 interpolation only, 10 hold only, 11 both.
- R10: `frame_start` clears the status. An interpolation or hold decided on that same edge is counted in the new frame.
- R11: After reset, `out_valid` is 0 and `conceal_status` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Channel of the input sample (0 left, 1 right) |
| in_sample | input | 16 | Two's-complement input sample |
| in_err | input | 1 | 1 marks the sample as uncorrectable |
| raw_mode | input | 1 | 1 disables concealment |
| frame_start | input | 1 | Clears the status field |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel of the output sample |
| out_sample | output | 16 | Concealed sample |
| conceal_status | output | 2 | bit0 interpolation seen, bit1 hold seen |

## Verification
The bench targets the following corner cases:
- **Flag at the start after reset.** A design that fails to start from zero would hold or interpolate against an undefined value.
- **Burst boundary.** An off-by-one at the transition would either hold the final flagged sample or interpolate the first one.
- **Negative and odd sums.** A wrong midpoint here shows up as an overflowed or truncated result.
- **Flags interleaved between channels.** If state were shared between channels, a hold on one channel would leak into the other.
- **Status updates.** These cover raw-mode samples and status events that coincide with a frame-start strobe, where a design that clears after counting, or that counts raw-mode outputs, reports the wrong code.

// File: rtl/conceal_pkg.sv
// Shared types for the concealment interpolator.
// Assumes: one decision per emitted sample, chosen per channel lane.
package conceal_pkg;
    localparam int STAT_W = 2;

    typedef enum logic [1:0] {
        ACT_PASS   = 2'd0,
        ACT_INTERP = 2'd1,
        ACT_HOLD   = 2'd2
    } conceal_act_e;
endpackage

// File: rtl/conceal_lane.sv
// One channel's concealment state: a one-sample lookahead register and the
// last good value. When the next sample of this channel is taken, the pending
// sample is resolved (pass, interpolate or hold) combinationally.
// Assumes: take is asserted only for samples of this lane's channel.
module conceal_lane
    import conceal_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] smp,
    input  logic              err,
    input  logic              raw,
    output logic              fire,
    output logic [DATA_W-1:0] res,
    output conceal_act_e      act
);
    localparam int SUM_W = DATA_W + 1;

    logic              pend_v;
    logic              pend_err;
    logic [DATA_W-1:0] pend_val;
    logic [DATA_W-1:0] last_good;
    logic [SUM_W-1:0]  mid_sum;

    // Sign-extended sum; dropping bit 0 is the arithmetic shift right by one.
    assign mid_sum = {last_good[DATA_W-1], last_good} + {smp[DATA_W-1], smp};

    // Resolve the pending sample once its successor's flag is known.
    always_comb begin
        fire = take && pend_v;
        if (!pend_err || raw) begin
            act = ACT_PASS;
            res = pend_val;
        end else if (err) begin
            act = ACT_HOLD;
            res = last_good;
        end else begin
            act = ACT_INTERP;
            res = mid_sum[SUM_W-1:1];
        end
    end

    // Advance the lookahead slot and remember the newest good value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_err  <= 1'b0;
            pend_val  <= '0;
            last_good <= '0;
        end else if (take) begin
            pend_v   <= 1'b1;
            pend_err <= err;
            pend_val <= smp;
            if (pend_v && !pend_err)
                last_good <= pend_val;
        end
    end

    // R1: a taken sample is always pending afterwards.
    p_pending_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> pend_v);

    // R7: the held value is 0 until a good sample has been resolved.
    p_hold_zero_before_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_v) |-> (last_good == '0));
endmodule

// File: rtl/conceal_status_acc.sv
// Sticky per-frame status: bit0 = interpolation seen, bit1 = hold seen.
// Assumes: frame_start clears first, then same-edge events are counted.
module conceal_status_acc
    import conceal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              ev_interp,
    input  logic              ev_hold,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] base;

    // Choose the value events accumulate onto this cycle.
    always_comb base = frame_start ? '0 : status;

    // Accumulate events into the sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= base | {ev_hold, ev_interp};
    end

    // R9: bits never drop inside a frame.
    p_sticky_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ((status | $past(status)) == status));

    // R10: a strobe with no event leaves a clean status.
    p_frame_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !ev_interp && !ev_hold) |=> (status == '0));
endmodule

// File: rtl/conceal_interp.sv
// Stereo concealment interpolator top: routes each input sample to its
// channel lane, registers whichever lane resolves a sample, and gathers the
// per-frame status. Assumes at most one input sample per clock.
module conceal_interp
    import conceal_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] in_chan,
    input  logic [DATA_W-1:0]                        in_sample,
    input  logic                                     in_err,
    input  logic                                     raw_mode,
    input  logic                                     frame_start,
    output logic                                     out_valid,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] out_chan,
    output logic [DATA_W-1:0]                        out_sample,
    output logic [STAT_W-1:0]                        conceal_status
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] fire_vec;
    logic [DATA_W-1:0] res_vec [NUM_CH];
    conceal_act_e      act_vec [NUM_CH];
    logic              any_fire;
    logic [CH_W-1:0]   sel_ch;
    logic [DATA_W-1:0] sel_res;
    logic              ev_interp;
    logic              ev_hold;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        conceal_lane #(.DATA_W(DATA_W)) lane_i (
            .clk  (clk),
            .rst_n(rst_n),
            .take (in_valid && (in_chan == CH_W'(g))),
            .smp  (in_sample),
            .err  (in_err),
            .raw  (raw_mode),
            .fire (fire_vec[g]),
            .res  (res_vec[g]),
            .act  (act_vec[g])
        );
    end

    // Pick the resolving lane and derive this cycle's status events.
    always_comb begin
        any_fire  = 1'b0;
        sel_ch    = '0;
        sel_res   = '0;
        ev_interp = 1'b0;
        ev_hold   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (fire_vec[i]) begin
                any_fire  = 1'b1;
                sel_ch    = CH_W'(i);
                sel_res   = res_vec[i];
                ev_interp = (act_vec[i] == ACT_INTERP);
                ev_hold   = (act_vec[i] == ACT_HOLD);
            end
        end
    end

    // Register the resolved sample onto the output port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_chan   <= '0;
            out_sample <= '0;
        end else begin
            out_valid <= any_fire;
            if (any_fire) begin
                out_chan   <= sel_ch;
                out_sample <= sel_res;
            end
        end
    end

    conceal_status_acc status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .ev_interp  (ev_interp),
        .ev_hold    (ev_hold),
        .status     (conceal_status)
    );

    // R1: an output is only ever produced by an accepted input.
    p_out_follows_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R2: only the addressed lane may resolve in a cycle.
    p_single_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_vec));

    // R8: raw mode never produces a concealment event.
    p_raw_no_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_mode |-> (!ev_interp && !ev_hold));
endmodule

// File: tb/conceal_interp_tb.sv
// Self-checking bench with a behavioural per-channel model compared every clock.
module conceal_interp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_chan = 1'b0, in_err = 1'b0;
    logic        raw_mode = 1'b0, frame_start = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid, out_chan;
    logic [15:0] out_sample;
    logic [1:0]  conceal_status;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // model state
    bit m_pv [2], m_perr [2];
    int m_pval [2], m_lg [2];
    int m_st = 0;

    always #4 clk = ~clk;

    conceal_interp dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .in_err(in_err), .raw_mode(raw_mode),
        .frame_start(frame_start), .out_valid(out_valid), .out_chan(out_chan),
        .out_sample(out_sample), .conceal_status(conceal_status)
    );

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit ch, input int s, input bit e,
                        input bit raw, input bit fs, input string tag);
        bit ev_i = 0, ev_h = 0, ev = 0;
        int es = 0;
        in_valid = v; in_chan = ch; in_sample = s[15:0]; in_err = e;
        raw_mode = raw; frame_start = fs;
        if (v) begin
            if (m_pv[ch]) begin
                ev = 1;
                if (!m_perr[ch] || raw) es = m_pval[ch];
                else if (e) begin es = m_lg[ch]; ev_h = 1; end
                else begin es = (m_lg[ch] + s) >>> 1; ev_i = 1; end
                if (!m_perr[ch]) m_lg[ch] = m_pval[ch];
            end
            m_pv[ch] = 1; m_pval[ch] = s; m_perr[ch] = e;
        end
        if (fs) m_st = 0;
        m_st = m_st | (ev_h << 1) | ev_i;
        @(posedge clk); #2;
        check({tag, " R1 valid"}, out_valid, ev);
        if (ev) begin
            check({tag, " R1 chan"}, out_chan, ch);
            check({tag, " sample"}, $signed(out_sample), es);
        end
        check(fs ? "R10 status" : "R9 status", conceal_status, m_st);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R11 valid", out_valid, 0);
        check("R11 status", conceal_status, 0);
        rst_n = 1'b1;
        // R7: flagged start, held at zero, then run end interpolates to zero mid
        step(1, 0, 1000, 1, 0, 0, "R7");
        step(1, 0, 2000, 1, 0, 0, "R7 hold");
        step(1, 0, 301, 0, 0, 0, "R6 run end");
        // R3 good samples on both channels
        step(1, 1, -5000, 0, 0, 0, "R3");
        step(1, 0, 400, 0, 0, 0, "R3");
        step(1, 1, -7001, 0, 0, 0, "R3");
        // R4 lone error on right, negative odd sum
        step(1, 1, 123, 1, 0, 0, "R4");
        step(1, 0, 32767, 0, 0, 1, "R10");
        step(1, 1, -32768, 0, 0, 0, "R4 mid");
        // R5/R6 burst on left interleaved with right goods (R2)
        step(1, 0, 11, 1, 0, 1, "R5");
        step(1, 1, 77, 0, 0, 0, "R2");
        step(1, 0, 22, 1, 0, 0, "R5 hold");
        step(1, 1, 78, 0, 0, 0, "R2");
        step(1, 0, 33, 1, 0, 0, "R5 hold");
        step(1, 0, -32768, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R1 idle");
        step(1, 0, 5, 0, 0, 0, "R6 mid");
        // R8 raw mode with flagged samples
        step(1, 1, 999, 1, 1, 1, "R8");
        step(1, 1, 888, 1, 1, 0, "R8 raw");
        step(1, 1, 777, 0, 1, 0, "R8 raw");
        step(1, 1, 666, 0, 0, 0, "R8 after");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            bit v  = ($urandom_range(0, 9) != 0);
            bit e  = ($urandom_range(0, 3) == 0);
            bit rw = ($urandom_range(0, 19) == 0);
            bit fs = ($urandom_range(0, 15) == 0);
            int s  = int'($urandom_range(0, 65535)) - 32768;
            step(v, $urandom_range(0, 1), s, e, rw, fs, "R2 R4 R5 R6 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule